// File: doc/BRIEF.md
# Boot Source Selection Sequencer

This block runs the boot flow of a two-core processor cluster after a power-on reset or a processor reset. While it works, the secondary core stays in reset. Three strap pins select where the first software image comes from: serial NOR flash, NAND flash, an SD/MMC card or the programmable fabric. The sequencer then asks that source to load the image. For a flash source, the load agent brings up the interface and copies the image into on-chip SRAM. For the fabric source, no request goes out until the fabric reports that it is both configured and in user mode.

A load attempt ends in one of three ways: the source reports completion, the source reports an error, or a cycle budget runs out. An error and an expired budget are both failures. After a failure the sequencer tries again from the source that last delivered a good image, if one is recorded. Otherwise it tries the fabric. If that last fallback also fails, the sequencer halts. The last-good record survives a processor reset and is cleared only by power-on reset. A successful load raises run-enable. The secondary core is released only when software asks for it after that point.

Top module: `boot_seq_top`

## Requirements
- R1: While either reset input is low, `load_req_o` is all zero, `run_en_o` is 0 and `sec_rst_o` is 1.
- R2: The pins are captured once, on the first clock edge after reset release, and later pin changes have no effect. The captured code maps to a source index as follows: 3'b000 selects 0 (NOR), 3'b001 selects 1 (NAND), 3'b010 selects 2 (SD/MMC), and 3'b011 or any code with bit 2 set selects 3 (fabric). The request for a non-fabric source appears two edges after reset release.
- R3: For source 3, `load_req_o` stays zero until an edge samples `fab_cfg_i` and `fab_user_i` both high. The request is visible after that edge.
- R4: During an attempt, `load_req_o` is one-hot, with bit i set for source i. Done and error bits of other sources are ignored.
- R5: When `load_done_i` is seen on the active source's bit, the next cycle shows `run_en_o`=1 and `load_req_o`=0, that source becomes the last-good record, and `run_en_o` then stays high until reset.
- R6: An attempt fails on an error bit or after `TMO_CYCLES` request cycles without done. Done wins over an error in the same cycle, and also wins in the last budget cycle.
- R7: When the pin-selected attempt fails and a last-good record exists, the next cycle starts an attempt on the last-good source.
- R8: When the pin-selected attempt fails with no record, or the last-good attempt fails, the next attempt is the fabric (source 3).
- R9: When the fabric fallback attempt fails, the sequencer halts: no request and no run-enable until reset, whatever the inputs do.
- R10: `sec_rst_o` stays 1 until `sec_release_i` is seen while `run_en_o` is 1, and falls one cycle later. A release request before that point is ignored.
- R11: The last-good record is kept across a low pulse on `rst_ni` alone and is cleared when `por_ni` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Processor reset, active low, asynchronous |
| por_ni | input | 1 | Power-on reset, active low, asynchronous; also clears last-good record |
| boot_pins_i | input | 3 | Boot-select strap pins |
| fab_cfg_i | input | 1 | Fabric reports configuration complete |
| fab_user_i | input | 1 | Fabric reports user mode |
| load_done_i | input | 4 | Per-source load complete |
| load_err_i | input | 4 | Per-source load error |
| sec_release_i | input | 1 | Software request to release the secondary core |
| load_req_o | output | 4 | Per-source load request, one-hot |
| sec_rst_o | output | 1 | Secondary core reset, active high |
| run_en_o | output | 1 | Boot core may run the loaded image |

## Verification
After reset release, the pins are captured on the first edge and the first request is due after the second edge. For a fabric source, the request comes one edge after both fabric status inputs are sampled high. A done, error or budget expiry sampled on an edge shows its result (run-enable, the next source's request, or halt) right after that edge, and a release request clears the secondary reset on the edge that samples it. The bench drives and samples on the falling edge only. It follows each attempt with a per-cycle loop, so every check lands in the cycle just after the edge that should have caused the change.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;
  localparam int unsigned PIN_W = 3;
  localparam int unsigned NSRC  = 4;
  localparam int unsigned SRC_W = $clog2(NSRC);

  typedef enum logic [SRC_W-1:0] {
    SRC_NOR  = 2'd0,
    SRC_NAND = 2'd1,
    SRC_SD   = 2'd2,
    SRC_FAB  = 2'd3
  } src_e;

  typedef enum logic [2:0] {
    ST_SAMPLE,
    ST_SELECT,
    ST_WAIT_FAB,
    ST_LOAD,
    ST_RUN,
    ST_HALT
  } state_e;

  typedef enum logic [1:0] {
    ATT_PIN,
    ATT_LG,
    ATT_FAB
  } att_e;

  // codes with the top pin set are reserved and default to the fabric
  function automatic src_e decode_pins(input logic [PIN_W-1:0] p);
    if (p[PIN_W-1]) return SRC_FAB;
    return src_e'(p[SRC_W-1:0]);
  endfunction
endpackage

// File: rtl/boot_pin_latch.sv
module boot_pin_latch
  import boot_seq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_i,
  input  logic [PIN_W-1:0] pins_i,
  output src_e             src_o
);
  src_e src_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    src_q <= SRC_FAB;
    else if (cap_i) src_q <= decode_pins(pins_i);
  end

  assign src_o = src_q;

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(src_q));
endmodule

// File: rtl/boot_lastgood.sv
module boot_lastgood
  import boot_seq_pkg::*;
(
  input  logic clk_i,
  input  logic por_ni,
  input  logic upd_i,
  input  src_e src_i,
  output logic valid_o,
  output src_e src_o
);
  logic valid_q;
  src_e src_q;

  // only power-on reset clears the record
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni) begin
      valid_q <= 1'b0;
      src_q   <= SRC_FAB;
    end else if (upd_i) begin
      valid_q <= 1'b1;
      src_q   <= src_i;
    end
  end

  assign valid_o = valid_q;
  assign src_o   = src_q;

  p_record_r11: assert property (@(posedge clk_i) disable iff (!por_ni)
    upd_i |=> (valid_o && src_o == $past(src_i)));
endmodule

// File: rtl/boot_load_timer.sv
module boot_load_timer #(
  parameter int unsigned TMO_CYCLES = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic expire_o
);
  localparam int unsigned CNT_W = (TMO_CYCLES > 2) ? $clog2(TMO_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TMO_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (run_i) cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = run_i && (cnt_q == LAST);

  p_no_overflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_o && !clr_i) |=> !run_i);
endmodule

// File: rtl/boot_seq_top.sv
module boot_seq_top
  import boot_seq_pkg::*;
#(
  parameter int unsigned TMO_CYCLES = 4096
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             por_ni,
  input  logic [PIN_W-1:0] boot_pins_i,
  input  logic             fab_cfg_i,
  input  logic             fab_user_i,
  input  logic [NSRC-1:0]  load_done_i,
  input  logic [NSRC-1:0]  load_err_i,
  input  logic             sec_release_i,
  output logic [NSRC-1:0]  load_req_o,
  output logic             sec_rst_o,
  output logic             run_en_o
);
  logic rst_n;
  assign rst_n = rst_ni & por_ni;

  state_e state_q, state_d;
  src_e   cur_src_q, cur_src_d;
  att_e   att_q, att_d;
  logic   sec_rst_q;

  src_e pin_src, lg_src;
  logic lg_valid, expire;
  logic done_hit, err_hit, fail, succeed;

  boot_pin_latch u_pins (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .cap_i  (state_q == ST_SAMPLE),
    .pins_i (boot_pins_i),
    .src_o  (pin_src)
  );

  boot_lastgood u_lastgood (
    .clk_i   (clk_i),
    .por_ni  (por_ni),
    .upd_i   (succeed),
    .src_i   (cur_src_q),
    .valid_o (lg_valid),
    .src_o   (lg_src)
  );

  boot_load_timer #(.TMO_CYCLES(TMO_CYCLES)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .clr_i    ((state_q != ST_LOAD) || fail),
    .run_i    (state_q == ST_LOAD),
    .expire_o (expire)
  );

  assign done_hit = load_done_i[cur_src_q];
  assign err_hit  = load_err_i[cur_src_q];
  assign succeed  = (state_q == ST_LOAD) && done_hit;
  assign fail     = (state_q == ST_LOAD) && !done_hit && (err_hit || expire);

  always_comb begin
    state_d   = state_q;
    cur_src_d = cur_src_q;
    att_d     = att_q;
    unique case (state_q)
      ST_SAMPLE: state_d = ST_SELECT;
      ST_SELECT: begin
        cur_src_d = pin_src;
        att_d     = ATT_PIN;
        state_d   = (pin_src == SRC_FAB) ? ST_WAIT_FAB : ST_LOAD;
      end
      ST_WAIT_FAB: if (fab_cfg_i && fab_user_i) state_d = ST_LOAD;
      ST_LOAD: begin
        if (succeed) begin
          state_d = ST_RUN;
        end else if (fail) begin
          if (att_q == ATT_PIN && lg_valid) begin
            cur_src_d = lg_src;
            att_d     = ATT_LG;
            state_d   = (lg_src == SRC_FAB) ? ST_WAIT_FAB : ST_LOAD;
          end else if (att_q != ATT_FAB) begin
            cur_src_d = SRC_FAB;
            att_d     = ATT_FAB;
            state_d   = ST_WAIT_FAB;
          end else begin
            state_d = ST_HALT;
          end
        end
      end
      ST_RUN:  state_d = ST_RUN;
      ST_HALT: state_d = ST_HALT;
      default: state_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_SAMPLE;
      cur_src_q <= SRC_FAB;
      att_q     <= ATT_PIN;
      sec_rst_q <= 1'b1;
    end else begin
      state_q   <= state_d;
      cur_src_q <= cur_src_d;
      att_q     <= att_d;
      if (state_q == ST_RUN && sec_release_i) sec_rst_q <= 1'b0;
    end
  end

  always_comb begin
    load_req_o = '0;
    if (state_q == ST_LOAD) load_req_o[cur_src_q] = 1'b1;
  end

  assign run_en_o  = (state_q == ST_RUN);
  assign sec_rst_o = sec_rst_q;

  p_req_onehot_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    $onehot0(load_req_o));
  p_fab_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(load_req_o[SRC_FAB]) |-> $past(fab_cfg_i && fab_user_i));
  p_run_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    run_en_o |=> run_en_o);
  p_sec_held_r10: assert property (@(posedge clk_i) disable iff (!rst_n)
    !run_en_o |-> sec_rst_o);
  p_sec_release_r10: assert property (@(posedge clk_i) disable iff (!rst_n)
    $fell(sec_rst_o) |-> $past(run_en_o && sec_release_i));
  p_halt_r9: assert property (@(posedge clk_i) disable iff (!rst_n)
    (state_q == ST_HALT) |=> (load_req_o == '0 && !run_en_o));
endmodule

// File: tb/tb_boot_seq_top.sv
`timescale 1ns/1ps
module tb_boot_seq_top;
  localparam int unsigned TMO = 8;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0, por_ni = 1'b0;
  logic [2:0] boot_pins_i = '0;
  logic       fab_cfg_i = 1'b0, fab_user_i = 1'b0;
  logic [3:0] load_done_i = '0, load_err_i = '0;
  logic       sec_release_i = 1'b0;
  logic [3:0] load_req_o;
  logic       sec_rst_o, run_en_o;

  int checks = 0;
  int errs   = 0;

  // outcome codes: 0 done, 1 error, 2 timeout, 3 done+error
  int  plan_oc[3];
  int  plan_k[3];
  bit  m_valid = 1'b0;
  int  m_src   = 0;

  always #2.5 clk_i = ~clk_i;

  boot_seq_top #(.TMO_CYCLES(TMO)) dut (
    .clk_i, .rst_ni, .por_ni, .boot_pins_i, .fab_cfg_i, .fab_user_i,
    .load_done_i, .load_err_i, .sec_release_i,
    .load_req_o, .sec_rst_o, .run_en_o
  );

  function automatic int exp_src(input logic [2:0] p);
    return p[2] ? 3 : int'(p[1:0]);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_ins();
    load_done_i = '0; load_err_i = '0; sec_release_i = 1'b0;
  endtask

  task automatic boot_reset(input bit por, input logic [2:0] pins);
    @(negedge clk_i);
    rst_ni = 1'b0; por_ni = !por;
    clear_ins(); fab_cfg_i = 1'b0; fab_user_i = 1'b0;
    boot_pins_i = pins;
    @(negedge clk_i);
    chk("R1 req", load_req_o, 4'b0);
    chk("R1 run", run_en_o, 1'b0);
    chk("R1 sec", sec_rst_o, 1'b1);
    rst_ni = 1'b1; por_ni = 1'b1;
    @(negedge clk_i);
    boot_pins_i = ~pins;        // late pin change must be ignored
    @(negedge clk_i);
  endtask

  task automatic attempt(input int src, input int oc, input int k, input string tag);
    int last;
    string t;
    t = (oc == 2) ? "R6" : tag;
    if (src == 3) begin
      bit r;
      r = 1'($urandom);
      fab_cfg_i = r; fab_user_i = !r;
      chk({tag, "/R3 wait"}, load_req_o, 4'b0);
      @(negedge clk_i);
      chk("R3 partial", load_req_o, 4'b0);
      fab_cfg_i = 1'b1; fab_user_i = 1'b1;
      @(negedge clk_i);
    end
    last = (oc == 2) ? int'(TMO) - 1 : k;
    for (int c = 0; c < int'(TMO); c++) begin
      chk({t, "/R4 req"}, load_req_o, 32'(1) << src);
      chk("R10 held", sec_rst_o, 1'b1);
      if (c == last && oc != 2) begin
        load_done_i[src] = (oc == 0 || oc == 3);
        load_err_i[src]  = (oc == 1 || oc == 3);
      end else begin
        load_done_i = 4'($urandom) & ~(4'b1 << src);
        load_err_i  = 4'($urandom) & ~(4'b1 << src);
      end
      sec_release_i = 1'($urandom);
      @(negedge clk_i);
      clear_ins();
      if (c == last) break;
    end
    fab_cfg_i = 1'b0; fab_user_i = 1'b0;
  endtask

  task automatic run_boot(input bit por, input logic [2:0] pins);
    int  src, att;
    bit  por_cleared;
    string tag;
    por_cleared = por && m_valid;
    if (por) m_valid = 1'b0;
    boot_reset(por, pins);
    src = exp_src(pins); att = 0; tag = "R2";
    for (int i = 0; i < 3; i++) begin
      attempt(src, plan_oc[i], plan_k[i], tag);
      if (plan_oc[i] == 0 || plan_oc[i] == 3) begin
        tag = (plan_oc[i] == 3 || plan_k[i] == int'(TMO) - 1) ? "R6 win" : "R5";
        chk({tag, " run"}, run_en_o, 1'b1);
        chk("R5 req off", load_req_o, 4'b0);
        chk("R10 held after run", sec_rst_o, 1'b1);
        m_valid = 1'b1; m_src = src;
        sec_release_i = 1'b1;
        @(negedge clk_i);
        sec_release_i = 1'b0;
        chk("R10 released", sec_rst_o, 1'b0);
        chk("R5 run sticky", run_en_o, 1'b1);
        return;
      end
      if (att == 0 && m_valid) begin
        src = m_src; att = 1; tag = "R7/R11";
      end else if (att != 2) begin
        src = 3; att = 2; tag = por_cleared ? "R11 cleared" : "R8";
      end else begin
        chk("R9 req", load_req_o, 4'b0);
        chk("R9 run", run_en_o, 1'b0);
        load_done_i = 4'hF; fab_cfg_i = 1'b1; fab_user_i = 1'b1;
        sec_release_i = 1'b1;
        repeat (3) @(negedge clk_i);
        chk("R9 req stuck", load_req_o, 4'b0);
        chk("R9 run stuck", run_en_o, 1'b0);
        chk("R9 sec", sec_rst_o, 1'b1);
        clear_ins(); fab_cfg_i = 1'b0; fab_user_i = 1'b0;
        return;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errs++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // NOR errors, no record: fabric, then done (R8)
    plan_oc = '{1, 0, 0}; plan_k = '{2, 1, 0};
    run_boot(1'b1, 3'b000);
    // SD done in last budget cycle (R6), record becomes SD
    plan_oc = '{0, 0, 0}; plan_k = '{TMO - 1, 0, 0};
    run_boot(1'b1, 3'b010);
    // NAND times out, SD retried and fails, fabric fails: halt (R7, R8, R9)
    plan_oc = '{2, 1, 1}; plan_k = '{0, 3, 0};
    run_boot(1'b0, 3'b001);
    // reserved code selects fabric, done+error wins
    plan_oc = '{3, 0, 0}; plan_k = '{4, 0, 0};
    run_boot(1'b0, 3'b110);
    // power-on clears the record: NOR fails straight to fabric (R11)
    plan_oc = '{1, 0, 0}; plan_k = '{0, 5, 0};
    run_boot(1'b1, 3'b000);
    for (int n = 0; n < 40; n++) begin
      for (int a = 0; a < 3; a++) begin
        plan_oc[a] = int'($urandom % 4);
        plan_k[a]  = int'($urandom % TMO);
      end
      run_boot(($urandom % 5) == 0, 3'($urandom));
    end
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule